// File: doc/BRIEF.md
# Bidirectional Serial Frequency-Word Loader

This block builds the tuning word for a phase accumulator from a serial bit stream. A 64-bit shift register takes one bit from `sdata` on every rising edge of `sclk` while the active-low `shift_en_n` is low. While `shift_en_n` is high, the register keeps its contents.

The `msb_first` input sets the shift direction, and it may change from bit to bit:

- When `msb_first` is 1, the register moves toward its top. Each new bit enters at bit 0.
- When `msb_first` is 0, the register moves toward its bottom. Each new bit enters at bit 63.

A single 32-bit load therefore ends up in a different half depending on the direction. The half-select input `sel_low_half` picks which half drives the 32-bit `active_word` output. For single-word use it must agree with the direction: both 1, or both 0.

A 64-bit load holds two words, and `sel_low_half` then switches between them with no reload. Reset is asynchronous active-low. Its release passes through a two-stage synchronizer on `sclk`.

Top module: `freq_word_loader`

## Requirements
- R1: While reset is applied, and after its release before any shift, all 64 register bits are zero, so `active_word` is 0 for both settings of `sel_low_half`.
- R2: With `shift_en_n` high, the register keeps every bit across any number of `sclk` edges, whatever `sdata` and `msb_first` do.
- R3: With `shift_en_n` low and `msb_first`=1, each edge moves bit i to bit i+1, drops bit 63 and places `sdata` in bit 0.
- R4: With `shift_en_n` low and `msb_first`=0, each edge moves bit i to bit i-1, drops bit 0 and places `sdata` in bit 63.
- R5: From a cleared register, 32 MSB-first shifts of a word W (bit 31 first) leave W in bits 31..0 and zero in bits 63..32.
- R6: From a cleared register, 32 LSB-first shifts of a word W (bit 0 first) leave W in bits 63..32 and zero in bits 31..0.
- R7: `active_word` equals register bits 31..0 when `sel_low_half`=1 and bits 63..32 when it is 0, with no clock delay.
- R8: After 64 MSB-first shifts of word A and then word B, bits 63..32 hold A and bits 31..0 hold B.
- R9: The direction is applied per edge, so a change of `msb_first` between two shifts takes effect on the very next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; the register shifts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized to sclk |
| shift_en_n | input | 1 | Active-low shift enable |
| sdata | input | 1 | Serial data bit |
| msb_first | input | 1 | 1: new bit enters at bit 0; 0: new bit enters at bit 63 |
| sel_low_half | input | 1 | 1: bits 31..0 drive the output; 0: bits 63..32 drive it |
| active_word | output | 32 | Selected 32-bit frequency word |

## Verification
The bench sweeps every partial load length from 1 to 32 in both directions. At each length it checks the growing half and the untouched half, so a reversed bit order, a shift entering at the wrong end, or an off-by-one in the entry position shows up as a wrong pattern at the first length.

A hold phase toggles `sdata` and `msb_first` while the enable is inactive. An enable with the wrong polarity would corrupt the loaded word there.

A two-word MSB-first load checks that the first word migrates into the upper half, which a design that saturates or wraps instead of discarding would get wrong.

A run that flips direction between single bits catches direction logic that is latched per load rather than applied on every edge.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic {
    DIR_TOWARD_BOTTOM = 1'b0,
    DIR_TOWARD_TOP    = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/fwl_rst_sync.sv
module fwl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fwl_shift_reg.sv
module fwl_shift_reg
  import fwl_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  shift_dir_e       dir,
  input  logic             sdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (shift_en) begin
      if (dir == DIR_TOWARD_TOP) begin
        q_nxt = {q[REG_W-2:0], sdata};
      end else begin
        q_nxt = {sdata, q[REG_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/fwl_half_mux.sv
module fwl_half_mux #(
  parameter int REG_W  = 64,
  localparam int HALF_W = REG_W / 2
) (
  input  logic [REG_W-1:0]  reg_bits,
  input  logic              sel_low,
  output logic [HALF_W-1:0] word
);
  logic [HALF_W-1:0] half_lo;
  logic [HALF_W-1:0] half_hi;

  genvar gi;
  generate
    for (gi = 0; gi < HALF_W; gi++) begin : g_split
      assign half_lo[gi] = reg_bits[gi];
      assign half_hi[gi] = reg_bits[HALF_W + gi];
    end
  endgenerate

  always_comb begin
    word = sel_low ? half_lo : half_hi;
  end
endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader
  import fwl_pkg::*;
#(
  parameter int REG_W      = 64,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_W    = REG_W / 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              shift_en_n,
  input  logic              sdata,
  input  logic              msb_first,
  input  logic              sel_low_half,
  output logic [HALF_W-1:0] active_word
);
  logic             rst_sync_n;
  logic             shift_en;
  shift_dir_e       dir;
  logic [REG_W-1:0] shift_q;

  assign shift_en = ~shift_en_n;
  assign dir      = msb_first ? DIR_TOWARD_TOP : DIR_TOWARD_BOTTOM;

  fwl_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (sclk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fwl_shift_reg #(.REG_W(REG_W)) shift_reg_i (
    .clk      (sclk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .dir      (dir),
    .sdata    (sdata),
    .q        (shift_q)
  );

  fwl_half_mux #(.REG_W(REG_W)) half_mux_i (
    .reg_bits (shift_q),
    .sel_low  (sel_low_half),
    .word     (active_word)
  );
endmodule

// File: rtl/freq_word_loader_chk.sv
module freq_word_loader_chk #(
  parameter int REG_W  = 64,
  localparam int HALF_W = REG_W / 2
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              shift_en_n,
  input logic              sdata,
  input logic              msb_first,
  input logic              sel_low_half,
  input logic [HALF_W-1:0] active_word,
  input logic [REG_W-1:0]  shift_q
);
  AST_RESET_CLEAR: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (shift_q == '0)); // R1

  AST_HOLD_DISABLED: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    shift_en_n |=> $stable(shift_q)); // R2

  AST_SHIFT_UP: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    (!shift_en_n && msb_first) |=>
      (shift_q[REG_W-1:1] == $past(shift_q[REG_W-2:0])) && (shift_q[0] == $past(sdata))); // R3

  AST_SHIFT_DOWN: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    (!shift_en_n && !msb_first) |=>
      (shift_q[REG_W-2:0] == $past(shift_q[REG_W-1:1])) && (shift_q[REG_W-1] == $past(sdata))); // R4

  always_comb begin
    if (rst_n && rst_sync_n) begin
      AST_HALF_SELECT: assert (active_word == (sel_low_half ? shift_q[HALF_W-1:0]
                                                             : shift_q[REG_W-1:HALF_W])); // R7
    end
  end
endmodule

bind freq_word_loader freq_word_loader_chk #(.REG_W(REG_W)) chk_i (
  .sclk         (sclk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .shift_en_n   (shift_en_n),
  .sdata        (sdata),
  .msb_first    (msb_first),
  .sel_low_half (sel_low_half),
  .active_word  (active_word),
  .shift_q      (shift_q)
);

// File: tb/freq_word_loader_tb_top.sv
module freq_word_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        sclk;
  logic        rst_n;
  logic        shift_en_n;
  logic        sdata;
  logic        msb_first;
  logic        sel_low_half;
  logic [31:0] active_word;

  int n_checks;
  int n_fails;
  bit finished;

  freq_word_loader dut_i (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .shift_en_n   (shift_en_n),
    .sdata        (sdata),
    .msb_first    (msb_first),
    .sel_low_half (sel_low_half),
    .active_word  (active_word)
  );

  initial sclk = 1'b0;
  always #(CLK_PERIOD/2) sclk = ~sclk;

  task automatic check_half(input logic sel, input logic [31:0] exp, input string req);
    sel_low_half = sel;
    #1;
    n_checks++;
    if (active_word !== exp) begin
      n_fails++;
      $display("FAIL %s sel=%0b actual=%h expected=%h", req, sel, active_word, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge sclk);
    shift_en_n = 1'b1;
    rst_n      = 1'b0;
    repeat (2) @(negedge sclk);
    rst_n = 1'b1;
    repeat (3) @(negedge sclk);
  endtask

  task automatic shift_one(input logic b, input logic up);
    @(negedge sclk);
    sdata      = b;
    msb_first  = up;
    shift_en_n = 1'b0;
    @(posedge sclk);
    #1;
    shift_en_n = 1'b1;
  endtask

  localparam logic [31:0] WORD_A = 32'hA5C3_0F96;
  localparam logic [31:0] WORD_B = 32'h1234_5678;
  localparam logic [31:0] WORD_C = 32'hF00D_8E21;

  initial begin
    rst_n = 1'b0; shift_en_n = 1'b1; sdata = 1'b0; msb_first = 1'b1; sel_low_half = 1'b1;
    n_checks = 0; n_fails = 0; finished = 0;

    // R1: reset state, both halves
    repeat (2) @(negedge sclk);
    check_half(1'b1, 32'h0, "R1");
    check_half(1'b0, 32'h0, "R1");
    do_reset();
    check_half(1'b1, 32'h0, "R1");
    check_half(1'b0, 32'h0, "R1");

    // R3/R7: MSB-first partial loads of WORD_A
    for (int k = 1; k <= 32; k++) begin
      shift_one(WORD_A[32-k], 1'b1);
      check_half(1'b1, WORD_A >> (32 - k), "R3");
      check_half(1'b0, 32'h0, "R7");
    end
    check_half(1'b1, WORD_A, "R5");
    check_half(1'b0, 32'h0, "R5");

    // R2: hold while enable inactive, inputs toggling
    for (int c = 0; c < 6; c++) begin
      @(negedge sclk);
      sdata = c[0]; msb_first = c[1];
    end
    check_half(1'b1, WORD_A, "R2");
    check_half(1'b0, 32'h0, "R2");

    // R8: second word pushes the first into the upper half
    for (int k = 1; k <= 32; k++) shift_one(WORD_B[32-k], 1'b1);
    check_half(1'b0, WORD_A, "R8");
    check_half(1'b1, WORD_B, "R8");

    // R4/R6: LSB-first partial loads of WORD_C from a cleared register
    do_reset();
    for (int k = 1; k <= 32; k++) begin
      logic [63:0] part;
      shift_one(WORD_C[k-1], 1'b0);
      part = ({32'h0, WORD_C} & ((64'h1 << k) - 64'h1)) << (32 - k);
      check_half(1'b0, part[31:0], "R4");
      check_half(1'b1, 32'h0, "R4");
    end
    check_half(1'b0, WORD_C, "R6");
    check_half(1'b1, 32'h0, "R6");

    // R9: direction changes take effect on the next shift
    do_reset();
    shift_one(1'b1, 1'b1);
    shift_one(1'b1, 1'b1);
    check_half(1'b1, 32'h3, "R9");
    shift_one(1'b0, 1'b0);
    check_half(1'b1, 32'h1, "R9");
    check_half(1'b0, 32'h0, "R9");
    shift_one(1'b1, 1'b0);
    check_half(1'b1, 32'h0, "R9");
    check_half(1'b0, 32'h8000_0000, "R9");
    shift_one(1'b0, 1'b1);
    check_half(1'b0, 32'h0, "R9");
    check_half(1'b1, 32'h0, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule